// File: doc/BRIEF.md
# Idle Channel Auto-Mute Detector

This block watches a stereo stream of received sample words and raises a mute flag once the source has gone quiet for a long stretch. A frame counts as quiet when both of its words are flat: every bit one, or every bit zero. The block counts consecutive quiet frames. Once the count reaches the threshold, and the active-low enable allows it, mute goes high.

Each frame arrives as a left word and a right word, qualified by a one-cycle frame strobe. The first frame that carries real activity drops mute at once and restarts the count. Raising the enable input forces mute low, but it does not stop the count, so re-enabling a channel that is still quiet mutes it again straight away. The analog mute action and any output ramping belong to the blocks that follow this one.

Top module: `idle_automute`

## Requirements
- R1: A word is flat when all SAMPLE_W bits are equal. A frame is quiet only when both words are flat. The two words may differ from each other (left all ones, right all zeros still counts as quiet). A single differing bit in either word, the MSB included, makes the frame active.
- R2: With the enable active (mute_en_n = 0), mute goes high at the clock edge that samples the IDLE_FRAMES-th consecutive quiet frame strobe (8192 by default). After IDLE_FRAMES-1 quiet frames, mute stays low.
- R3: An active frame strobe drives mute low at the edge that samples it and resets the count to zero. A full IDLE_FRAMES further quiet frames are then needed to mute again.
- R4: The count saturates at IDLE_FRAMES. Any number of further quiet frames keeps mute high and never wraps the count.
- R5: mute_en_n = 1 forces mute low at the next edge while quiet frames keep being counted. When mute_en_n returns to 0 with the count at threshold, mute rises at the next edge.
- R6: On cycles where frame_stb is low, the sample inputs have no effect on the count or on mute.
- R7: A synchronous active-low reset clears the count and mute. After reset, a full IDLE_FRAMES quiet frames are needed to mute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-cycle qualifier for a received frame |
| left_word | input | SAMPLE_W | Left sample of the frame |
| right_word | input | SAMPLE_W | Right sample of the frame |
| mute_en_n | input | 1 | Auto-mute enable, active low |
| mute | output | 1 | High while the channel is judged idle and muting is enabled |

## Verification
The detector is driven with several kinds of input. All-zero frames and all-ones frames show the threshold edge at 8191 versus 8192 frames. Mixed flat frames, with left all ones and right all zeros, show that each word is judged on its own. Single-bit deviations, including the MSB alone, show that near-flat data is treated as activity. Strobe gaps carrying busy-looking data show that only qualified frames count. Enable toggling and a mid-run reset separate a count that has stopped from one that keeps tracking while output is suppressed.

// File: rtl/idle_mute_pkg.sv
// Package: shared types for the idle auto-mute detector.
// Assumes: nothing beyond IEEE 1800-2017.
package idle_mute_pkg;
    // Classification of one received frame.
    typedef enum logic {
        FRAME_ACTIVE = 1'b0,
        FRAME_QUIET  = 1'b1
    } frame_kind_e;

    // Default sample width and idle threshold in frames.
    localparam int DEF_SAMPLE_W    = 20;
    localparam int DEF_IDLE_FRAMES = 8192;
    localparam int NUM_CH          = 2;
endpackage

// File: rtl/flat_word_detect.sv
// Module: flat_word_detect
// Flags a sample word whose bits are all one or all zero.
// Assumes: purely combinational; the caller qualifies it with its strobe.
module flat_word_detect #(
    parameter int SAMPLE_W = 20
) (
    input  logic [SAMPLE_W-1:0] word,
    output logic                flat
);
    // Flat when every bit is set or no bit is set.
    always_comb begin
        flat = (&word) | ~(|word);
    end
endmodule

// File: rtl/idle_run_counter.sv
// Module: idle_run_counter
// Counts consecutive quiet frames, saturating at IDLE_FRAMES.
// Assumes: frame_stb is high for one cycle per frame; rst_n is synchronous.
module idle_run_counter
    import idle_mute_pkg::*;
#(
    parameter int IDLE_FRAMES = 8192
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_stb,
    input  frame_kind_e frame_kind,
    output logic        full_next,
    output logic        full_now
);
    localparam int             CNT_W = $clog2(IDLE_FRAMES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_FRAMES);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next count: hold without a strobe, restart on activity, saturate when quiet.
    always_comb begin
        cnt_d = cnt_q;
        if (frame_stb) begin
            if (frame_kind == FRAME_QUIET) begin
                cnt_d = (cnt_q == LIMIT) ? LIMIT : cnt_q + 1'b1;
            end else begin
                cnt_d = '0;
            end
        end
    end

    // Count register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Threshold flags for the current and the next count.
    always_comb begin
        full_next = (cnt_d == LIMIT);
        full_now  = (cnt_q == LIMIT);
    end

    assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);
    assert_restart_on_activity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && frame_kind == FRAME_ACTIVE) |=> (cnt_q == '0));
    assert_hold_without_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(cnt_q));
    assert_stay_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full_now && frame_stb && frame_kind == FRAME_QUIET) |=> full_now);
endmodule

// File: rtl/mute_gate.sv
// Module: mute_gate
// Registers the mute flag from the threshold flag and the active-low enable.
// Assumes: full_next is the threshold state the counter will hold after this edge.
module mute_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en_n,
    input  logic full_next,
    input  logic full_now,
    output logic mute
);
    logic mute_q;

    // Mute follows the threshold only while the enable is low.
    always_ff @(posedge clk) begin
        if (!rst_n) mute_q <= 1'b0;
        else        mute_q <= !en_n && full_next;
    end

    assign mute = mute_q;

    assert_mute_needs_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mute |-> full_now);
    assert_disable_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> !mute);
endmodule

// File: rtl/idle_automute.sv
// Module: idle_automute (top)
// Detects an idle stereo input (flat words over IDLE_FRAMES consecutive frames)
// and raises mute while the active-low enable is asserted.
// Assumes: one frame per frame_stb pulse; synchronous active-low reset.
module idle_automute
    import idle_mute_pkg::*;
#(
    parameter int SAMPLE_W    = DEF_SAMPLE_W,
    parameter int IDLE_FRAMES = DEF_IDLE_FRAMES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_stb,
    input  logic [SAMPLE_W-1:0] left_word,
    input  logic [SAMPLE_W-1:0] right_word,
    input  logic                mute_en_n,
    output logic                mute
);
    logic [SAMPLE_W-1:0] ch_word [NUM_CH];
    logic [NUM_CH-1:0]   ch_flat;
    frame_kind_e         frame_kind;
    logic                full_next;
    logic                full_now;

    // Gather both channel words into one array.
    always_comb begin
        ch_word[0] = left_word;
        ch_word[1] = right_word;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        flat_word_detect #(.SAMPLE_W(SAMPLE_W)) u_flat (
            .word (ch_word[c]),
            .flat (ch_flat[c])
        );
    end

    // A frame is quiet only when every channel word is flat.
    always_comb begin
        frame_kind = (&ch_flat) ? FRAME_QUIET : FRAME_ACTIVE;
    end

    idle_run_counter #(.IDLE_FRAMES(IDLE_FRAMES)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .frame_kind (frame_kind),
        .full_next  (full_next),
        .full_now   (full_now)
    );

    mute_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_n      (mute_en_n),
        .full_next (full_next),
        .full_now  (full_now),
        .mute      (mute)
    );

    assert_activity_unmutes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !((&left_word | ~(|left_word)) && (&right_word | ~(|right_word))))
        |=> !mute);
    assert_reenable_mutes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full_now && !frame_stb && !mute_en_n) |=> mute);
endmodule

// File: tb/tb_idle_automute.sv
module tb_idle_automute;
    localparam int W = 20;
    localparam int N = 8192;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_stb = 1'b0;
    logic [W-1:0] left_word = '0;
    logic [W-1:0] right_word = '0;
    logic         mute_en_n = 1'b0;
    logic         mute;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    localparam logic [W-1:0] ONES = {W{1'b1}};
    localparam logic [W-1:0] ZERO = '0;

    always #2 clk = ~clk;

    idle_automute #(.SAMPLE_W(W), .IDLE_FRAMES(N)) dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .left_word(left_word), .right_word(right_word),
        .mute_en_n(mute_en_n), .mute(mute)
    );

    task automatic check(input logic exp, input string req);
        n_checks++;
        if (mute !== exp) begin
            n_fails++;
            $display("FAIL %s: mute=%b expected %b at %0t", req, mute, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; frame_stb = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Send n back-to-back frames; returns at the negedge after the last one.
    task automatic send(input int n, input logic [W-1:0] l, input logic [W-1:0] r);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_stb = 1'b1; left_word = l; right_word = r;
        end
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check(1'b0, "R7 reset state");
    endtask

    task automatic t_threshold();
        do_reset();
        send(N - 1, ZERO, ZERO);
        check(1'b0, "R2 below threshold zeros");
        send(1, ZERO, ZERO);
        check(1'b1, "R2 at threshold zeros");
        send(5000, ZERO, ZERO);
        check(1'b1, "R4 saturation keeps mute");
    endtask

    task automatic t_activity();
        send(1, 20'h12345, ZERO);
        check(1'b0, "R3 activity releases mute");
        send(N - 1, ONES, ONES);
        check(1'b0, "R3 count restarted, ones below threshold");
        send(1, ONES, ONES);
        check(1'b1, "R3 ones reach threshold again");
    endtask

    task automatic t_gaps();
        do_reset();
        send(N - 1, ZERO, ZERO);
        left_word = 20'h5A5A5; right_word = 20'h0F0F0;
        repeat (20) @(negedge clk);
        check(1'b0, "R6 unstrobed data ignored");
        send(1, ZERO, ZERO);
        check(1'b1, "R6 count held across gap");
    endtask

    task automatic t_mixed();
        do_reset();
        send(N, ONES, ZERO);
        check(1'b1, "R1 mixed flat words are quiet");
        send(1, ONES, 20'h00001);
        check(1'b0, "R1 single LSB makes frame active");
        send(N, ZERO, ONES);
        check(1'b1, "R1 swapped mixed flat words");
        send(1, 20'h80000, ZERO);
        check(1'b0, "R1 MSB alone makes frame active");
    endtask

    task automatic t_enable();
        do_reset();
        mute_en_n = 1'b1;
        send(N + 10, ZERO, ZERO);
        check(1'b0, "R5 disabled never mutes");
        mute_en_n = 1'b0;
        @(negedge clk);
        check(1'b1, "R5 re-enable with full count mutes");
        mute_en_n = 1'b1;
        @(negedge clk);
        check(1'b0, "R5 disable clears mute next edge");
        mute_en_n = 1'b0;
        @(negedge clk);
        check(1'b1, "R5 enable again");
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(1'b0, "R7 reset clears mute");
        send(N - 1, ZERO, ZERO);
        check(1'b0, "R7 full run needed after reset");
        send(1, ZERO, ZERO);
        check(1'b1, "R7 mutes after full run");
    endtask

    initial begin
        t_reset_state();
        t_threshold();
        t_activity();
        t_gaps();
        t_mixed();
        t_enable();
        t_reset_mid();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule